// File: doc/BRIEF.md
# Overlay Memory Address Decoder

This block sits between a processor core and its memory system. For each access it takes a 14-bit core address and a space selector, which names either the program space or the data space. It then decides whether the word lives in on-chip RAM, in the on-chip control-register block, or in external memory. One 8K half of each space is fixed. The other half is a window that a 2-bit overlay code steers either to internal RAM or to one of two external 8K pages. The page number is driven on the top external address line, and the 13 low address bits are passed straight through.

External accesses pull the program or data select strobe low (both active-low). External data accesses are stretched by a programmable number of wait cycles. Internal accesses finish in one cycle. An access whose overlay code is reserved, or that breaks the boot-mode rule, raises an error flag, drives no strobe and completes at once. A new request is taken when the block is idle or in the last cycle of the current access. A request at any other time is dropped.

Top module: `ovl_addr_decoder`

## Requirements
- R1: After reset, and whenever reset is asserted in the middle of an access, done_o, err_o, int_o and mmr_o are 0, ext_addr_o is 0, and pm_sel_no and dm_sel_no are 1.
- R2: A program access (space_i=0) with boot_ext_i=0 and address 0x0000–0x1FFF goes to internal RAM, whatever pm_ovl_i holds.
- R3: A program access with boot_ext_i=0 and address 0x2000–0x3FFF follows pm_ovl_i: code 0 goes to internal RAM. Code 1 goes to external memory with ext_addr_o[13]=0, and code 2 goes to external memory with ext_addr_o[13]=1. In both external cases ext_addr_o[12:0] equals addr_i[12:0].
- R4: With boot_ext_i=1 and pm_ovl_i=0, a program access to 0x0000–0x1FFF is external with ext_addr_o={1'b0, addr_i[12:0]}, and one to 0x2000–0x3FFF is internal. With boot_ext_i=1 and a nonzero pm_ovl_i, any program access is an error.
- R5: A data access (space_i=1) to 0x2000–0x3FDF is internal regardless of dm_ovl_i. A data access to 0x0000–0x1FFF follows dm_ovl_i with the same code meanings as in R3. boot_ext_i has no effect on data accesses.
- R6: A data access to 0x3FE0–0x3FFF raises mmr_o, not int_o, and drives no strobe.
- R7: An access that decodes to overlay code 3 raises err_o together with done_o for one cycle, and leaves both strobes high and ext_addr_o at 0.
- R8: An external data access holds dm_sel_no low and ext_addr_o steady for dwait_i+1 cycles after acceptance (dwait_i is sampled at acceptance, 0 to 7). done_o is high only in the last of those cycles.
- R9: Internal, register-block, error and external program accesses last exactly one cycle whatever dwait_i holds, with done_o high in the cycle after acceptance.
- R10: pm_sel_no is low only during external program accesses and dm_sel_no only during external data accesses. Both are never low together. ext_addr_o is 0 whenever no external access is in progress.
- R11: A request (rd_i or wr_i) made while an access is in progress and not in its last cycle is ignored. A request made in the last cycle starts the next access in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 14 | Core address |
| space_i | input | 1 | 0 = program space, 1 = data space |
| rd_i | input | 1 | Read request |
| wr_i | input | 1 | Write request |
| boot_ext_i | input | 1 | Boot mode: lower program half external |
| pm_ovl_i | input | 2 | Program overlay code |
| dm_ovl_i | input | 2 | Data overlay code |
| dwait_i | input | 3 | Wait cycles for external data accesses |
| done_o | output | 1 | High in the final cycle of an access |
| err_o | output | 1 | Access decoded to an illegal overlay setting |
| int_o | output | 1 | Access targets internal RAM |
| mmr_o | output | 1 | Access targets the control-register block |
| ext_addr_o | output | 14 | External address, page bit on the top line |
| pm_sel_no | output | 1 | External program select, active low |
| dm_sel_no | output | 1 | External data select, active low |

## Verification
The decode table is driven through each space with both address halves and every overlay code. The overlay register of the other space is always held at the reserved code, so any cross-coupling between the two registers would show up as an error. Wait counts of 0, 3, 6 and 7 are applied to external data accesses and to program and internal accesses. Comparing the measured access lengths separates stretching that is applied correctly from stretching that leaks onto the wrong access kinds. Boot mode is tried with a zero and a nonzero overlay code, and data accesses are run under boot mode to confirm it has no effect there. The edges 0x3FDF/0x3FE0 and 0x1FFF/0x2000 show where the register block and the overlay window begin. Directed sequences check that a request in a middle cycle is dropped, that one in the last cycle chains straight on, and that reset clears an access in progress.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
  typedef enum logic [1:0] {
    RGN_INT = 2'd0,
    RGN_EXT = 2'd1,
    RGN_MMR = 2'd2,
    RGN_ERR = 2'd3
  } rgn_e;
endpackage

// File: rtl/ovl_region_map.sv
module ovl_region_map
  import ovl_pkg::*;
#(
  parameter int ADDR_W   = 14,
  parameter int OVL_W    = 2,
  parameter int REG_WORDS = 32
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              space_i,
  input  logic              boot_ext_i,
  input  logic [OVL_W-1:0]  pm_ovl_i,
  input  logic [OVL_W-1:0]  dm_ovl_i,
  output rgn_e              rgn_o,
  output logic              page_o
);
  localparam int REG_BITS = $clog2(REG_WORDS);
  localparam int HI       = ADDR_W - 1;

  logic upper;
  assign upper = addr_i[HI];

  // overlay code -> region/page for the switchable half
  function automatic void ovl_decode(input logic [OVL_W-1:0] code,
                                     output rgn_e r, output logic pg);
    pg = 1'b0;
    if (code == OVL_W'(0))      r = RGN_INT;
    else if (code == OVL_W'(1)) r = RGN_EXT;
    else if (code == OVL_W'(2)) begin r = RGN_EXT; pg = 1'b1; end
    else                        r = RGN_ERR;
  endfunction

  always_comb begin
    rgn_o  = RGN_INT;
    page_o = 1'b0;
    if (!space_i) begin
      if (boot_ext_i) begin
        if (pm_ovl_i != '0) rgn_o = RGN_ERR;
        else if (!upper)    rgn_o = RGN_EXT;
        else                rgn_o = RGN_INT;
      end else if (upper) begin
        ovl_decode(pm_ovl_i, rgn_o, page_o);
      end
    end else begin
      if (upper) begin
        rgn_o = (&addr_i[HI:REG_BITS]) ? RGN_MMR : RGN_INT;
      end else begin
        ovl_decode(dm_ovl_i, rgn_o, page_o);
      end
    end
  end
endmodule

// File: rtl/ovl_wait_ctr.sv
module ovl_wait_ctr #(
  parameter int WAIT_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [WAIT_W-1:0] wait_i,
  output logic              active_o,
  output logic              last_o
);
  logic [WAIT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o <= 1'b0;
      cnt_q    <= '0;
    end else if (start_i) begin
      active_o <= 1'b1;
      cnt_q    <= wait_i;
    end else if (active_o) begin
      if (cnt_q == '0) active_o <= 1'b0;
      else             cnt_q    <= cnt_q - 1'b1;
    end
  end

  assign last_o = active_o && (cnt_q == '0);

  p_busy_until_last_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_o && !last_o |=> active_o);

  p_load_len_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && (wait_i == '0) |=> last_o);
endmodule

// File: rtl/ovl_addr_decoder.sv
module ovl_addr_decoder
  import ovl_pkg::*;
#(
  parameter int ADDR_W    = 14,
  parameter int OVL_W     = 2,
  parameter int WAIT_W    = 3,
  parameter int REG_WORDS = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              space_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic              boot_ext_i,
  input  logic [OVL_W-1:0]  pm_ovl_i,
  input  logic [OVL_W-1:0]  dm_ovl_i,
  input  logic [WAIT_W-1:0] dwait_i,
  output logic              done_o,
  output logic              err_o,
  output logic              int_o,
  output logic              mmr_o,
  output logic [ADDR_W-1:0] ext_addr_o,
  output logic              pm_sel_no,
  output logic              dm_sel_no
);
  localparam int LO_W = ADDR_W - 1;

  rgn_e              rgn_d, rgn_q;
  logic              page_d;
  logic              space_q;
  logic [ADDR_W-1:0] eaddr_q;
  logic              active, last, accept, req;
  logic [WAIT_W-1:0] load_wait;

  ovl_region_map #(
    .ADDR_W(ADDR_W), .OVL_W(OVL_W), .REG_WORDS(REG_WORDS)
  ) u_map (
    .addr_i    (addr_i),
    .space_i   (space_i),
    .boot_ext_i(boot_ext_i),
    .pm_ovl_i  (pm_ovl_i),
    .dm_ovl_i  (dm_ovl_i),
    .rgn_o     (rgn_d),
    .page_o    (page_d)
  );

  assign req    = rd_i | wr_i;
  assign accept = req && (!active || last);
  // only external data accesses are stretched
  assign load_wait = (space_i && rgn_d == RGN_EXT) ? dwait_i : '0;

  ovl_wait_ctr #(.WAIT_W(WAIT_W)) u_wait (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (accept),
    .wait_i  (load_wait),
    .active_o(active),
    .last_o  (last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rgn_q   <= RGN_INT;
      space_q <= 1'b0;
      eaddr_q <= '0;
    end else if (accept) begin
      rgn_q   <= rgn_d;
      space_q <= space_i;
      eaddr_q <= (rgn_d == RGN_EXT) ? {page_d, addr_i[LO_W-1:0]} : '0;
    end
  end

  logic ext_act;
  assign ext_act    = active && (rgn_q == RGN_EXT);
  assign done_o     = last;
  assign err_o      = active && (rgn_q == RGN_ERR);
  assign int_o      = active && (rgn_q == RGN_INT);
  assign mmr_o      = active && (rgn_q == RGN_MMR);
  assign ext_addr_o = ext_act ? eaddr_q : '0;
  assign pm_sel_no  = !(ext_act && !space_q);
  assign dm_sel_no  = !(ext_act && space_q);

  p_err_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (pm_sel_no && dm_sel_no && done_o && ext_addr_o == '0));

  p_int_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && rgn_d == RGN_INT |=> done_o && int_o);

  p_boot_low_ext_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && !space_i && boot_ext_i && pm_ovl_i == '0 && !addr_i[ADDR_W-1]
    |=> !pm_sel_no && ext_addr_o[ADDR_W-1] == 1'b0);

  p_hold_addr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active && !last |=> $stable(ext_addr_o) && $stable(dm_sel_no));

  p_strobe_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pm_sel_no |-> dm_sel_no);

  p_mmr_no_strobe_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mmr_o |-> (pm_sel_no && dm_sel_no && !int_o));
endmodule

// File: tb/ovl_addr_decoder_test.sv
module ovl_addr_decoder_test;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [13:0] addr_i = '0;
  logic        space_i = 1'b0;
  logic        rd_i = 1'b0;
  logic        wr_i = 1'b0;
  logic        boot_ext_i = 1'b0;
  logic [1:0]  pm_ovl_i = '0;
  logic [1:0]  dm_ovl_i = '0;
  logic [2:0]  dwait_i = '0;
  logic        done_o, err_o, int_o, mmr_o, pm_sel_no, dm_sel_no;
  logic [13:0] ext_addr_o;

  int n_chk = 0;
  int n_fail = 0;
  bit ended = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  ovl_addr_decoder uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .space_i(space_i),
    .rd_i(rd_i), .wr_i(wr_i), .boot_ext_i(boot_ext_i),
    .pm_ovl_i(pm_ovl_i), .dm_ovl_i(dm_ovl_i), .dwait_i(dwait_i),
    .done_o(done_o), .err_o(err_o), .int_o(int_o), .mmr_o(mmr_o),
    .ext_addr_o(ext_addr_o), .pm_sel_no(pm_sel_no), .dm_sel_no(dm_sel_no)
  );

  // kd: 0 internal, 1 external, 2 register block, 3 error
  typedef struct packed {
    logic        sp;
    logic        bt;
    logic [1:0]  ov;
    logic [2:0]  ws;
    logic [13:0] ad;
    logic [1:0]  kd;
    logic [13:0] ea;
    logic [3:0]  cy;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 2'd0, 3'd5, 14'h0100, 2'd0, 14'h0000, 4'd1},
    '{1'b0, 1'b0, 2'd0, 3'd0, 14'h2345, 2'd0, 14'h0000, 4'd1},
    '{1'b0, 1'b0, 2'd1, 3'd5, 14'h2345, 2'd1, 14'h0345, 4'd1},
    '{1'b0, 1'b0, 2'd2, 3'd0, 14'h3FFF, 2'd1, 14'h3FFF, 4'd1},
    '{1'b0, 1'b0, 2'd3, 3'd0, 14'h2000, 2'd3, 14'h0000, 4'd1},
    '{1'b0, 1'b0, 2'd3, 3'd0, 14'h1FFF, 2'd0, 14'h0000, 4'd1},
    '{1'b0, 1'b1, 2'd0, 3'd4, 14'h0ABC, 2'd1, 14'h0ABC, 4'd1},
    '{1'b0, 1'b1, 2'd0, 3'd0, 14'h2ABC, 2'd0, 14'h0000, 4'd1},
    '{1'b0, 1'b1, 2'd1, 3'd0, 14'h0ABC, 2'd3, 14'h0000, 4'd1},
    '{1'b1, 1'b0, 2'd0, 3'd3, 14'h0123, 2'd0, 14'h0000, 4'd1},
    '{1'b1, 1'b0, 2'd1, 3'd0, 14'h1123, 2'd1, 14'h1123, 4'd1},
    '{1'b1, 1'b0, 2'd2, 3'd3, 14'h0123, 2'd1, 14'h2123, 4'd4},
    '{1'b1, 1'b0, 2'd2, 3'd7, 14'h1FFF, 2'd1, 14'h3FFF, 4'd8},
    '{1'b1, 1'b0, 2'd3, 3'd0, 14'h0040, 2'd3, 14'h0000, 4'd1},
    '{1'b1, 1'b0, 2'd3, 3'd2, 14'h2040, 2'd0, 14'h0000, 4'd1},
    '{1'b1, 1'b0, 2'd0, 3'd0, 14'h3FDF, 2'd0, 14'h0000, 4'd1},
    '{1'b1, 1'b0, 2'd1, 3'd6, 14'h3FE0, 2'd2, 14'h0000, 4'd1},
    '{1'b1, 1'b1, 2'd0, 3'd0, 14'h3FFF, 2'd2, 14'h0000, 4'd1}
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  endtask

  function automatic string req_of(input vec_t v);
    if (v.kd == 2'd3) return "R7";
    if (v.kd == 2'd2) return "R6";
    if (v.sp) return "R5";
    if (v.bt) return "R4";
    if (!v.ad[13]) return "R2";
    return "R3";
  endfunction

  // drive one request at a negedge; outputs checked from the first access cycle
  task automatic issue(input logic sp, input logic bt, input logic [1:0] pov,
                       input logic [1:0] dov, input logic [2:0] ws,
                       input logic [13:0] ad, input logic wr);
    @(negedge clk_i);
    space_i = sp; boot_ext_i = bt; pm_ovl_i = pov; dm_ovl_i = dov;
    dwait_i = ws; addr_i = ad; rd_i = !wr; wr_i = wr;
    @(negedge clk_i);
    rd_i = 1'b0; wr_i = 1'b0;
  endtask

  task automatic chk_idle(input string req);
    chk(req, "done", 32'(done_o), 32'd0);
    chk(req, "err", 32'(err_o), 32'd0);
    chk(req, "int", 32'(int_o), 32'd0);
    chk(req, "mmr", 32'(mmr_o), 32'd0);
    chk(req, "eaddr", 32'(ext_addr_o), 32'd0);
    chk(req, "pm_sel", 32'(pm_sel_no), 32'd1);
    chk(req, "dm_sel", 32'(dm_sel_no), 32'd1);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog act=timeout exp=finish");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk_idle("R1");
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk_idle("R1");

    for (int i = 0; i < NV; i++) begin
      vec_t  v;
      string rq;
      int    cyc;
      logic  ext;
      v  = VECS[i];
      rq = req_of(v);
      ext = (v.kd == 2'd1);
      issue(v.sp, v.bt, v.sp ? 2'd3 : v.ov, v.sp ? v.ov : 2'd3, v.ws, v.ad, i[0]);
      chk(rq, "err", 32'(err_o), 32'(v.kd == 2'd3));
      chk(rq, "int", 32'(int_o), 32'(v.kd == 2'd0));
      chk(rq, "mmr", 32'(mmr_o), 32'(v.kd == 2'd2));
      chk(rq, "eaddr", 32'(ext_addr_o), 32'(v.ea));
      cyc = 1;
      while (!done_o && cyc < 12) begin
        chk("R8", "dm_sel_mid", 32'(dm_sel_no), 32'(!(ext && v.sp)));
        chk("R8", "eaddr_mid", 32'(ext_addr_o), 32'(v.ea));
        @(negedge clk_i);
        cyc++;
      end
      chk("R10", "pm_sel", 32'(pm_sel_no), 32'(!(ext && !v.sp)));
      chk("R10", "dm_sel", 32'(dm_sel_no), 32'(!(ext && v.sp)));
      chk((v.sp && ext) ? "R8" : "R9", "cycles", 32'(cyc), 32'(v.cy));
      @(negedge clk_i);
      chk_idle("R10");
    end

    // request in a middle cycle is dropped
    issue(1'b1, 1'b0, 2'd0, 2'd1, 3'd3, 14'h0010, 1'b0);
    chk("R11", "done_c1", 32'(done_o), 32'd0);
    space_i = 1'b0; addr_i = 14'h0005; rd_i = 1'b1;
    @(negedge clk_i);
    rd_i = 1'b0;
    chk("R11", "dm_sel_c2", 32'(dm_sel_no), 32'd0);
    @(negedge clk_i);
    chk("R11", "eaddr_c3", 32'(ext_addr_o), 32'h0010);
    chk("R11", "int_c3", 32'(int_o), 32'd0);
    @(negedge clk_i);
    chk("R11", "done_c4", 32'(done_o), 32'd1);
    @(negedge clk_i);
    chk_idle("R11");

    // request in the last cycle chains on
    issue(1'b1, 1'b0, 2'd0, 2'd1, 3'd1, 14'h0020, 1'b1);
    chk("R11", "done_b1", 32'(done_o), 32'd0);
    @(negedge clk_i);
    chk("R11", "done_b2", 32'(done_o), 32'd1);
    space_i = 1'b0; addr_i = 14'h0005; rd_i = 1'b1;
    @(negedge clk_i);
    rd_i = 1'b0;
    chk("R11", "int_next", 32'(int_o), 32'd1);
    chk("R11", "done_next", 32'(done_o), 32'd1);
    chk("R11", "dm_sel_next", 32'(dm_sel_no), 32'd1);
    @(negedge clk_i);
    chk_idle("R11");

    // reset in the middle of a stretched access
    issue(1'b1, 1'b0, 2'd0, 2'd2, 3'd7, 14'h0777, 1'b0);
    chk("R8", "dm_sel_pre", 32'(dm_sel_no), 32'd0);
    rst_ni = 1'b0;
    #1;
    chk_idle("R1");
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk_idle("R1");

    finish_run();
  end
endmodule